// File: doc/BRIEF.md
# Nine-Port GPIO Bank with Bit-Set and Bit-Clear Access

This block is a register-mapped bank of general-purpose I/O. It has nine ports of eight pins each. Each pin has an output data bit and a direction bit. The block drives a per-pin output value and output enable toward the pads, and it samples the pad inputs through a synchronizer so software can read them.

Software reaches the block over a plain byte-wide register bus with an address, a write strobe, a read strobe, write data and registered read data. The bus has no back-pressure: every strobe is accepted in the cycle it is sampled, and read data comes back exactly one cycle later.

Besides plain writes to the data register, each port offers two ways to change single bits without a read-modify-write:
- The address that reads the live pin state, when written, ORs the written ones into the output data.
- A separate clear address, when written, keeps only the data bits where the written byte has a one. Writing a zero bit clears that data bit.

Top module: `gpio_bank`

## Requirements
- R1: While reset is held and after it is released, every data and direction bit is 0, `pad_oe` and `pad_out` are all 0, and `bus_rdata` is 0.
- R2: Port k (k = 0..8) has its output data register at byte offset 0x00+k. A write replaces all eight bits, and a read returns the stored value.
- R3: Port k has its direction register at offset 0x0C+k, and it can be read and written. Pin bit b of port k appears at index 8k+b of the pad vectors. A direction bit of 1 asserts that pin's `pad_oe` and drives its data bit on `pad_out`. A direction bit of 0 deasserts `pad_oe` and forces `pad_out` to 0.
- R4: A read of offset 0x18+k returns the synchronized pad inputs of port k, not its data register.
- R5: A write to offset 0x18+k sets every data bit of port k whose written bit is 1. Bits written as 0 keep their value.
- R6: A write to offset 0x24+k clears every data bit of port k whose written bit is 0. Bits written as 1 keep their value.
- R7: A read of offset 0x24+k returns the current data register of port k.
- R8: These offsets are unmapped: 0x09–0x0B, 0x15–0x17, 0x21–0x23 and 0x2D–0x3F. A read of an unmapped offset returns 0, and a write to one changes no data or direction bit.
- R9: A write takes effect on the clock edge that samples `bus_we`, and `pad_out`/`pad_oe` show it right after that edge. Read data appears on `bus_rdata` in the cycle after the edge that samples `bus_re`. In any cycle that does not follow a sampled read, `bus_rdata` is 0.
- R10: Pad inputs pass through two flops before they reach the pin-state reads. Suppose a pad changes between two edges. A read sampled on the first or second edge after the change returns the old value, and a read sampled on the third edge returns the new value.
- R11: A write to one port's register leaves the data and direction of every other port unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_re | input | 1 | Read strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Registered read data, valid the cycle after the read strobe |
| pad_in | input | 72 | Pad input values, port k at bits 8k+7..8k |
| pad_out | output | 72 | Pad output values |
| pad_oe | output | 72 | Pad output enables, 1 = drive |

## Verification
Register writes change `pad_out` and `pad_oe` right after the sampling edge. The bench drives each strobe from one falling edge to the next and checks the pads at that next falling edge. Read results are due one edge after the strobe, so the bench samples `bus_rdata` at the falling edge that ends the strobe. It also checks for 0 one cycle later, when no read is pending.

Pad inputs need three edges before a read returns them. A directed sequence reads the pins on the first, second and third edge after a change and expects old, old, new. During random traffic, every pad change is followed by two idle cycles before any pin read.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Register class selected by a bus offset.
  typedef enum logic [2:0] {
    RGN_NONE = 3'd0,
    RGN_DATA = 3'd1,
    RGN_DIR  = 3'd2,
    RGN_PIN  = 3'd3,
    RGN_CLR  = 3'd4
  } region_e;

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int WIDTH  = 72,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[0] <= '0;
          else        stage[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[s] <= '0;
          else        stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];

endmodule

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_PORTS = 9,
  parameter int DATA_BASE = 'h00,
  parameter int DIR_BASE  = 'h0C,
  parameter int PIN_BASE  = 'h18,
  parameter int CLR_BASE  = 'h24,
  parameter int IDX_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [IDX_W-1:0]  idx
);

  int a;

  always_comb begin
    a      = int'(addr);
    region = RGN_NONE;
    idx    = '0;
    if (a >= DATA_BASE && a < DATA_BASE + NUM_PORTS) begin
      region = RGN_DATA;
      idx    = IDX_W'(a - DATA_BASE);
    end else if (a >= DIR_BASE && a < DIR_BASE + NUM_PORTS) begin
      region = RGN_DIR;
      idx    = IDX_W'(a - DIR_BASE);
    end else if (a >= PIN_BASE && a < PIN_BASE + NUM_PORTS) begin
      region = RGN_PIN;
      idx    = IDX_W'(a - PIN_BASE);
    end else if (a >= CLR_BASE && a < CLR_BASE + NUM_PORTS) begin
      region = RGN_CLR;
      idx    = IDX_W'(a - CLR_BASE);
    end
  end

endmodule

// File: rtl/gpio_bank_port.sv
module gpio_bank_port #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data,
  input  logic              wr_dir,
  input  logic              wr_set,
  input  logic              wr_clr,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] data_q,
  output logic [PORT_W-1:0] dir_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_data)     data_q <= wdata;
      else if (wr_set) data_q <= data_q | wdata;
      else if (wr_clr) data_q <= data_q & wdata;
      if (wr_dir)      dir_q  <= wdata;
    end
  end

  // R5: set access only raises bits named by ones
  a_r5_set_merges: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> data_q == ($past(data_q) | $past(wdata)));

  // R6: clear access keeps only bits written as one
  a_r6_clr_masks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> data_q == ($past(data_q) & $past(wdata)));

  // R11: with no access aimed at this port its state holds
  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_data || wr_set || wr_clr || wr_dir) |=> ($stable(data_q) && $stable(dir_q)));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS   = 9,
  parameter int PORT_W      = 8,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_BASE   = 'h00,
  parameter int DIR_BASE    = 'h0C,
  parameter int PIN_BASE    = 'h18,
  parameter int CLR_BASE    = 'h24,
  localparam int TOTAL_W    = NUM_PORTS * PORT_W,
  localparam int IDX_W      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic               bus_re,
  input  logic [PORT_W-1:0]  bus_wdata,
  output logic [PORT_W-1:0]  bus_rdata,
  input  logic [TOTAL_W-1:0] pad_in,
  output logic [TOTAL_W-1:0] pad_out,
  output logic [TOTAL_W-1:0] pad_oe
);

  region_e             region;
  logic [IDX_W-1:0]    idx;
  logic [TOTAL_W-1:0]  pin_sync;
  logic [TOTAL_W-1:0]  data_flat;
  logic [TOTAL_W-1:0]  dir_flat;
  logic [PORT_W-1:0]   rd_mux;

  gpio_bank_decode #(
    .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .DATA_BASE(DATA_BASE),
    .DIR_BASE(DIR_BASE), .PIN_BASE(PIN_BASE), .CLR_BASE(CLR_BASE), .IDX_W(IDX_W)
  ) u_decode (
    .addr(bus_addr), .region(region), .idx(idx)
  );

  gpio_bank_sync #(.WIDTH(TOTAL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  generate
    for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
      logic hit;
      assign hit = bus_we && (idx == IDX_W'(k));

      gpio_bank_port #(.PORT_W(PORT_W)) u_port (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_data(hit && region == RGN_DATA),
        .wr_dir (hit && region == RGN_DIR),
        .wr_set (hit && region == RGN_PIN),
        .wr_clr (hit && region == RGN_CLR),
        .wdata  (bus_wdata),
        .data_q (data_flat[k*PORT_W +: PORT_W]),
        .dir_q  (dir_flat[k*PORT_W +: PORT_W])
      );

      assign pad_oe[k*PORT_W +: PORT_W]  = dir_flat[k*PORT_W +: PORT_W];
      assign pad_out[k*PORT_W +: PORT_W] = data_flat[k*PORT_W +: PORT_W]
                                         & dir_flat[k*PORT_W +: PORT_W];
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      if (idx == IDX_W'(k)) begin
        unique case (region)
          RGN_DATA: rd_mux = data_flat[k*PORT_W +: PORT_W];
          RGN_CLR:  rd_mux = data_flat[k*PORT_W +: PORT_W];
          RGN_DIR:  rd_mux = dir_flat[k*PORT_W +: PORT_W];
          RGN_PIN:  rd_mux = pin_sync[k*PORT_W +: PORT_W];
          default:  rd_mux = rd_mux;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end

  // R9: no read sampled means zero read data next cycle
  a_r9_rdata_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> bus_rdata == '0);

  // R8: writes to holes in the map touch no register
  a_r8_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && region == RGN_NONE) |=> ($stable(data_flat) && $stable(dir_flat)));

  // R8: reads of holes return zero
  a_r8_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && region == RGN_NONE) |=> bus_rdata == '0);

  // R3: an undriven pin never shows a one on its output value
  a_r3_input_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

endmodule

// File: tb/gpio_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_tb_top;
  localparam int NP = 9;
  localparam int TW = NP * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic          bus_re = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [TW-1:0] pad_in = '0;
  logic [TW-1:0] pad_out;
  logic [TW-1:0] pad_oe;

  always #2.5 clk = ~clk;

  gpio_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  logic [7:0] m_data [NP];
  logic [7:0] m_dir  [NP];

  function automatic logic [TW-1:0] exp_out();
    logic [TW-1:0] r;
    for (int k = 0; k < NP; k++) r[k*8 +: 8] = m_data[k] & m_dir[k];
    return r;
  endfunction

  function automatic logic [TW-1:0] exp_oe();
    logic [TW-1:0] r;
    for (int k = 0; k < NP; k++) r[k*8 +: 8] = m_dir[k];
    return r;
  endfunction

  function automatic bit mapped(input int a);
    return (a <= 'h08) || (a >= 'h0C && a <= 'h14) ||
           (a >= 'h18 && a <= 'h20) || (a >= 'h24 && a <= 'h2C);
  endfunction

  // Reference register model computed from the requirements.
  function automatic void model_write(input int a, input logic [7:0] d);
    if (a <= 'h08)                   m_data[a]        = d;
    else if (a >= 'h0C && a <= 'h14) m_dir[a-'h0C]    = d;
    else if (a >= 'h18 && a <= 'h20) m_data[a-'h18]  |= d;
    else if (a >= 'h24 && a <= 'h2C) m_data[a-'h24]  &= d;
  endfunction

  function automatic logic [7:0] model_read(input int a);
    if (a <= 'h08)                   return m_data[a];
    if (a >= 'h0C && a <= 'h14)      return m_dir[a-'h0C];
    if (a >= 'h18 && a <= 'h20)      return pad_in[(a-'h18)*8 +: 8];
    if (a >= 'h24 && a <= 'h2C)      return m_data[a-'h24];
    return 8'h00;
  endfunction

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_pads(input string tag);
    n_vec++;
    if (pad_out !== exp_out() || pad_oe !== exp_oe()) begin
      n_bad++;
      $display("FAIL %s actual out=%h oe=%h expected out=%h oe=%h",
               tag, pad_out, pad_oe, exp_out(), exp_oe());
    end
  endtask

  // Tasks start and end on a falling edge.
  task automatic wr(input int a, input logic [7:0] d);
    bus_addr = 6'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    bus_addr = 6'(a); bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    v = bus_rdata;
  endtask

  task automatic rd_chk(input string tag, input int a);
    logic [7:0] v;
    logic [7:0] e;
    e = model_read(a);
    rd(a, v);
    chk8(tag, v, e);
  endtask

  initial begin
    logic [7:0] v;
    logic [TW-1:0] old_pad;
    logic [TW-1:0] new_pad;
    void'($urandom(32'h5EED_0042));
    for (int k = 0; k < NP; k++) begin m_data[k] = '0; m_dir[k] = '0; end

    // R1: state during reset
    repeat (3) @(negedge clk);
    chk_pads("R1 pads in reset");
    chk8("R1 rdata in reset", bus_rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk_pads("R1 pads after reset");
    for (int k = 0; k < NP; k++) begin
      rd_chk("R1 data reset", k);
      rd_chk("R1 dir reset", 'h0C + k);
    end

    // R2 / R3: plain data and direction access on the edge ports
    wr('h00, 8'hA5); chk_pads("R2 data written, pins inputs");
    wr('h0C, 8'hF0); chk_pads("R3 dir upper nibble drives");
    rd_chk("R2 data readback", 'h00);
    rd_chk("R3 dir readback", 'h0C);
    wr('h08, 8'h3C); wr('h14, 8'hFF); chk_pads("R3 last port fully driven");

    // R5: set through pin address, R7 clear address reads data
    wr('h18 + 8, 8'h81); chk_pads("R5 set ones on port 8");
    rd_chk("R7 clear reg reads data", 'h24 + 8);
    wr('h18 + 8, 8'h00); chk_pads("R5 zero set has no effect");
    // R6: zero bits clear, all-ones is a no-op
    wr('h24 + 8, 8'hF0); chk_pads("R6 clear low nibble");
    wr('h24 + 8, 8'hFF); chk_pads("R6 all ones keeps data");
    rd_chk("R6 data after clear", 'h08);

    // R9: read data returns to zero without a strobe
    @(negedge clk);
    chk8("R9 rdata idle zero", bus_rdata, 8'h00);

    // R4 / R10: synchronizer latency, read 1st/2nd/3rd edge after change
    old_pad = pad_in;
    new_pad = {9{8'h5A}};
    pad_in = new_pad;
    rd('h18 + 4, v); chk8("R10 first edge old", v, old_pad[39:32]);
    rd('h18 + 4, v); chk8("R10 second edge old", v, old_pad[39:32]);
    rd('h18 + 4, v); chk8("R10 third edge new", v, new_pad[39:32]);
    rd_chk("R4 pin read not data", 'h18 + 8);

    // R8: holes in the map
    rd_chk("R8 unmapped read 0x09", 'h09);
    rd_chk("R8 unmapped read 0x3F", 'h3F);
    wr('h15, 8'hFF); chk_pads("R8 unmapped write ignored");
    rd_chk("R8 data port0 intact", 'h00);

    // Random traffic
    for (int it = 0; it < 600; it++) begin
      int op;
      int p;
      int a;
      op = int'($urandom_range(0, 7));
      p  = int'($urandom_range(0, NP - 1));
      case (op)
        0: begin wr('h00 + p, 8'($urandom)); chk_pads("R2 random data write"); end
        1: begin wr('h0C + p, 8'($urandom)); chk_pads("R3 random dir write"); end
        2: begin wr('h18 + p, 8'($urandom)); chk_pads("R5 random set"); end
        3: begin wr('h24 + p, 8'($urandom)); chk_pads("R6 random clear"); end
        4: begin
          case ($urandom_range(0, 2))
            0: rd_chk("R2 random data read", 'h00 + p);
            1: rd_chk("R3 random dir read", 'h0C + p);
            default: rd_chk("R7 random clear read", 'h24 + p);
          endcase
        end
        5: rd_chk("R4 random pin read", 'h18 + p);
        6: begin
          for (int w = 0; w < TW; w += 32) pad_in[w +: 8] = 8'($urandom);
          for (int w = 8; w < TW; w += 8) pad_in[w +: 8] = 8'($urandom);
          repeat (2) @(negedge clk);
        end
        default: begin
          do a = int'($urandom_range(0, 63)); while (mapped(a));
          if ($urandom_range(0, 1) == 0) begin
            wr(a, 8'($urandom)); chk_pads("R8 random hole write");
            rd_chk("R11 data after hole write", 'h00 + p);
          end else begin
            rd_chk("R8 random hole read", a);
          end
        end
      endcase
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R9 watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule